// File: doc/BRIEF.md
# Page-Window Request Router

This block steers memory requests across an on-chip fabric. It holds a small bank of programmable 64-bit window descriptors. Each descriptor names a range of 4 KB pages, a destination port, a required value of the request's special-cycle flag, and a signed page offset. Every incoming request is tested against all descriptors in parallel. The result is registered once and delivered as a routing decision: a hit or miss, the destination port, and the page-translated address.

Software-side configuration uses a plain register port: a select, a write enable, 64-bit write data and combinational read data. The request side is a valid/ready stream. The single output register may hold a result while the consumer stalls, and the request side only accepts a new request when that register is empty or being drained in the same cycle. The input stream carries no storage of its own. A producer must therefore keep `req_valid`, `req_addr` and `req_special` steady until it sees `req_ready` high at a clock edge.

Top module: `route_window_bank`

## Requirements
- R1: After reset, every descriptor reads back 64'h00000000_000FFFFF, and no request hits any descriptor, whatever its address or flag.
- R2: A descriptor word is laid out as port [63:61], special compare bit [60], signed page offset [59:40], upper page bound [39:20] and lower page bound [19:0]. A write with a select of 0..NUM_DESC-1 is visible on `cfg_rdata` from the next clock. A select of NUM_DESC or higher reads zero, and writes with it change no descriptor.
- R3: A descriptor can hit only when address bits [31:12], compared unsigned, are at least the lower bound and at most the upper bound. Both bounds are inclusive.
- R4: A descriptor can hit only when `req_special` equals its compare bit [60].
- R5: On a hit, `rsp_port` is the winning descriptor's bits [63:61]. `rsp_addr` is {(addr[31:12] + offset) mod 2^20, addr[11:0]}.
- R6: When several descriptors hit, the lowest-numbered one supplies port and address. `rsp_multi` is 1 exactly when two or more descriptors hit.
- R7: When nothing hits, `rsp_miss` is 1, `rsp_hit` is 0, `rsp_port` is 0 and `rsp_addr` equals the request address.
- R8: A request accepted at a clock edge (`req_valid` and `req_ready` both high) appears on the outputs with `rsp_valid` high right after that edge. The decision uses the descriptor values from before any write made at the same edge.
- R9: `req_ready` is high exactly when `rsp_valid` is low or `rsp_ready` is high. While `rsp_valid` is high and `rsp_ready` is low, every response output holds its value.
- R10: When a response is consumed and no request is accepted at the same edge, `rsp_valid` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sel | input | SEL_W (2) | Descriptor select for reads and writes |
| cfg_we | input | 1 | Write strobe for the selected descriptor |
| cfg_wdata | input | 64 | Descriptor write data |
| cfg_rdata | output | 64 | Selected descriptor, zero when the select is out of range |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at the next edge when valid |
| req_addr | input | 32 | Physical request address |
| req_special | input | 1 | Special-cycle flag of the request |
| rsp_valid | output | 1 | Routing decision present |
| rsp_ready | input | 1 | Consumer takes the decision |
| rsp_hit | output | 1 | Some descriptor hit |
| rsp_miss | output | 1 | No descriptor hit |
| rsp_multi | output | 1 | Two or more descriptors hit |
| rsp_port | output | 3 | Destination port of the winning descriptor |
| rsp_addr | output | 32 | Translated (or passed-through) address |

## Verification
Register writes become visible on `cfg_rdata` one edge after the strobe. A request is decided at the edge that accepts it, so its result is due one edge later. The bench drives inputs on the falling edge and samples on the next falling edge, which lies after exactly one rising edge. During stalls, the bench samples the held response over several falling edges, and then expects the queued request's result one edge after `rsp_ready` rises. Expected values come from a bench-side model of the descriptors that the bench itself wrote.

// File: rtl/rwb_pkg.sv
package rwb_pkg;
  localparam int ADDR_W  = 32;
  localparam int PAGE_W  = 12;
  localparam int PN_W    = ADDR_W - PAGE_W;
  localparam int PORT_W  = 3;
  localparam int DESC_W  = PORT_W + 1 + 3 * PN_W;

  typedef struct packed {
    logic [PORT_W-1:0] port;
    logic              spc;
    logic [PN_W-1:0]   offset;
    logic [PN_W-1:0]   pmax;
    logic [PN_W-1:0]   pmin;
  } desc_t;

  localparam desc_t DESC_RESET = '{port: '0, spc: 1'b0, offset: '0,
                                   pmax: '0, pmin: '1};
endpackage

// File: rtl/rwb_desc_regs.sv
module rwb_desc_regs
  import rwb_pkg::*;
#(
  parameter int NUM_DESC = 3,
  parameter int SEL_W    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SEL_W-1:0]       cfg_sel,
  input  logic                   cfg_we,
  input  logic [DESC_W-1:0]      cfg_wdata,
  output logic [DESC_W-1:0]      cfg_rdata,
  output desc_t [NUM_DESC-1:0]   desc_o
);
  desc_t [NUM_DESC-1:0] desc_q;

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  desc_q[g] <= DESC_RESET;
      else if (cfg_we && (cfg_sel == SEL_W'(g)))   desc_q[g] <= desc_t'(cfg_wdata);
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_DESC; i++) begin
      if (cfg_sel == SEL_W'(i)) cfg_rdata = desc_q[i];
    end
  end

  assign desc_o = desc_q;

  // R2
  oor_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cfg_sel) >= NUM_DESC) |=> $stable(desc_q));
endmodule

// File: rtl/rwb_window_match.sv
module rwb_window_match
  import rwb_pkg::*;
(
  input  desc_t            desc_i,
  input  logic [PN_W-1:0]  page_i,
  input  logic             special_i,
  output logic             hit_o,
  output logic [PN_W-1:0]  page_xlat_o
);
  logic above_min, below_max, flag_ok;

  assign above_min   = (page_i >= desc_i.pmin);
  assign below_max   = (page_i <= desc_i.pmax);
  assign flag_ok     = (special_i == desc_i.spc);
  assign hit_o       = above_min && below_max && flag_ok;
  assign page_xlat_o = page_i + desc_i.offset;
endmodule

// File: rtl/rwb_resp_stage.sv
module rwb_resp_stage
  import rwb_pkg::*;
#(
  parameter int NUM_DESC = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  output logic                              req_ready,
  input  logic [ADDR_W-1:0]                 req_addr,
  input  logic [NUM_DESC-1:0]               hit_i,
  input  logic [NUM_DESC-1:0][PN_W-1:0]     xlat_i,
  input  logic [NUM_DESC-1:0][PORT_W-1:0]   port_i,
  output logic                              rsp_valid,
  input  logic                              rsp_ready,
  output logic                              rsp_hit,
  output logic                              rsp_miss,
  output logic                              rsp_multi,
  output logic [PORT_W-1:0]                 rsp_port,
  output logic [ADDR_W-1:0]                 rsp_addr
);
  logic              win_hit, win_multi;
  logic [PORT_W-1:0] win_port;
  logic [PN_W-1:0]   win_page;

  always_comb begin
    win_hit   = 1'b0;
    win_multi = 1'b0;
    win_port  = '0;
    win_page  = req_addr[ADDR_W-1:PAGE_W];
    for (int i = 0; i < NUM_DESC; i++) begin
      if (hit_i[i]) begin
        if (win_hit) begin
          win_multi = 1'b1;
        end else begin
          win_hit  = 1'b1;
          win_port = port_i[i];
          win_page = xlat_i[i];
        end
      end
    end
  end

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_multi <= 1'b0;
      rsp_port  <= '0;
      rsp_addr  <= '0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit   <= win_hit;
        rsp_miss  <= !win_hit;
        rsp_multi <= win_multi;
        rsp_port  <= win_port;
        rsp_addr  <= {win_page, req_addr[PAGE_W-1:0]};
      end
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) &&
      $stable(rsp_port) && $stable(rsp_hit) && $stable(rsp_multi)));

  // R8
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R10
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && !req_valid) |=> !rsp_valid);

  // R6
  multi_implies_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_multi) |-> rsp_hit);
endmodule

// File: rtl/route_window_bank.sv
module route_window_bank
  import rwb_pkg::*;
#(
  parameter  int NUM_DESC = 3,
  localparam int SEL_W    = ($clog2(NUM_DESC + 1) > 0) ? $clog2(NUM_DESC + 1) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SEL_W-1:0]     cfg_sel,
  input  logic                 cfg_we,
  input  logic [DESC_W-1:0]    cfg_wdata,
  output logic [DESC_W-1:0]    cfg_rdata,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_special,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic                 rsp_hit,
  output logic                 rsp_miss,
  output logic                 rsp_multi,
  output logic [PORT_W-1:0]    rsp_port,
  output logic [ADDR_W-1:0]    rsp_addr
);
  desc_t [NUM_DESC-1:0]              desc_all;
  logic  [NUM_DESC-1:0]              hits;
  logic  [NUM_DESC-1:0][PN_W-1:0]    xlat;
  logic  [NUM_DESC-1:0][PORT_W-1:0]  ports;

  rwb_desc_regs #(.NUM_DESC(NUM_DESC), .SEL_W(SEL_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_sel   (cfg_sel),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .desc_o    (desc_all)
  );

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_win
    rwb_window_match u_match (
      .desc_i      (desc_all[g]),
      .page_i      (req_addr[ADDR_W-1:PAGE_W]),
      .special_i   (req_special),
      .hit_o       (hits[g]),
      .page_xlat_o (xlat[g])
    );
    assign ports[g] = desc_all[g].port;

    // R4
    flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hits[g] |-> (req_special == desc_all[g].spc));
  end

  rwb_resp_stage #(.NUM_DESC(NUM_DESC)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .hit_i     (hits),
    .xlat_i    (xlat),
    .port_i    (ports),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_multi (rsp_multi),
    .rsp_port  (rsp_port),
    .rsp_addr  (rsp_addr)
  );
endmodule

// File: tb/tb_route_window_bank.sv
`timescale 1ns/1ps
module tb_route_window_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic        cfg_we = 1'b0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_special = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit, rsp_miss, rsp_multi;
  logic [2:0]  rsp_port;
  logic [31:0] rsp_addr;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  logic [63:0] mdl [3];

  always #5 clk = ~clk;

  route_window_bank dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(logic [2:0] port, logic spc, logic [19:0] off,
                                     logic [19:0] pmax, logic [19:0] pmin);
    return {port, spc, off, pmax, pmin};
  endfunction

  task automatic wr(int sel, logic [63:0] d);
    @(negedge clk);
    cfg_sel = 2'(sel); cfg_wdata = d; cfg_we = 1'b1;
    if (sel < 3) mdl[sel] = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // bench model of the routing decision
  task automatic expect_for(logic [31:0] a, logic s, output logic h, output logic m,
                            output logic [2:0] p, output logic [31:0] x);
    h = 0; m = 0; p = 0; x = a;
    for (int i = 0; i < 3; i++) begin
      logic [19:0] pg, lo, hi;
      pg = a[31:12]; lo = mdl[i][19:0]; hi = mdl[i][39:20];
      if (pg >= lo && pg <= hi && s == mdl[i][60]) begin
        if (h) m = 1;
        else begin
          h = 1; p = mdl[i][63:61];
          x = {20'(pg + mdl[i][59:40]), a[11:0]};
        end
      end
    end
  endtask

  task automatic send(string req, logic [31:0] a, logic s);
    logic h, m; logic [2:0] p; logic [31:0] x;
    expect_for(a, s, h, m, p, x);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_special = s;
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " valid"}, 64'(rsp_valid), 64'd1);
    chk({req, " hit"},   64'(rsp_hit),   64'(h));
    chk({req, " miss"},  64'(rsp_miss),  64'(!h));
    chk({req, " multi"}, 64'(rsp_multi), 64'(m));
    chk({req, " port"},  64'(rsp_port),  64'(p));
    chk({req, " addr"},  64'(rsp_addr),  64'(x));
  endtask

  task automatic t_reset;
    for (int i = 0; i < 3; i++) begin
      cfg_sel = 2'(i); #1;
      chk("R1 reset value", cfg_rdata, 64'h00000000_000FFFFF);
    end
    chk("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    send("R1 no hit at page 0", 32'h0000_0123, 1'b0);
    chk("R1 explicit miss", 64'(rsp_miss), 64'd1);
    send("R1 no hit at top page", 32'hFFFF_F000, 1'b1);
  endtask

  task automatic t_regs;
    wr(0, mk(3'd5, 1'b0, 20'h00010, 20'h001FF, 20'h00100));
    wr(1, mk(3'd2, 1'b1, 20'hFFFFF, 20'h00300, 20'h00150));
    wr(2, mk(3'd7, 1'b0, 20'h00002, 20'h00400, 20'h00180));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); cfg_sel = 2'(i); #1;
      chk("R2 readback", cfg_rdata, mdl[i]);
    end
    wr(3, 64'hDEAD_BEEF_0000_1111);
    cfg_sel = 2'd3; #1;
    chk("R2 out-of-range read zero", cfg_rdata, 64'd0);
    for (int i = 0; i < 3; i++) begin
      cfg_sel = 2'(i); #1;
      chk("R2 out-of-range write ignored", cfg_rdata, mdl[i]);
    end
  endtask

  task automatic t_bounds;
    send("R3 below lower bound", 32'h000F_FABC, 1'b0);
    send("R3 at lower bound",    32'h0010_0ABC, 1'b0);
    chk("R3 lower bound hit", 64'(rsp_hit), 64'd1);
    send("R3 at upper bound",    32'h001F_F001, 1'b0);
    chk("R3 upper bound hit", 64'(rsp_hit), 64'd1);
    send("R3 past last window",  32'h0040_1000, 1'b0);
    chk("R7 miss passthrough", 64'(rsp_addr), 64'h0040_1000);
  endtask

  task automatic t_special;
    send("R4 flag high picks desc1", 32'h0016_0010, 1'b1);
    chk("R4 port of desc1", 64'(rsp_port), 64'd2);
    send("R4 flag high outside desc1", 32'h0010_0010, 1'b1);
    chk("R4 flag mismatch miss", 64'(rsp_hit), 64'd0);
  endtask

  task automatic t_translate;
    send("R5 positive offset", 32'h0012_3456, 1'b0);
    chk("R5 translated addr", 64'(rsp_addr), 64'h0013_3456);
    send("R5 negative offset", 32'h0030_0FFF, 1'b1);
    chk("R5 minus one page", 64'(rsp_addr), 64'h002F_FFFF);
    wr(2, mk(3'd6, 1'b0, 20'h00020, 20'hFFFFF, 20'hFFFF0));
    send("R5 wrap", 32'hFFFF_8ABC, 1'b0);
    chk("R5 wrapped addr", 64'(rsp_addr), 64'h0001_8ABC);
    chk("R5 wrap port", 64'(rsp_port), 64'd6);
  endtask

  task automatic t_priority;
    wr(2, mk(3'd4, 1'b0, 20'h00003, 20'h00400, 20'h00180));
    send("R6 overlap desc0 desc2", 32'h0018_8000, 1'b0);
    chk("R6 lowest wins port", 64'(rsp_port), 64'd5);
    chk("R6 multi flag", 64'(rsp_multi), 64'd1);
    send("R6 only desc2", 32'h0025_0000, 1'b0);
    chk("R6 single no multi", 64'(rsp_multi), 64'd0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    cfg_sel = 2'd0; cfg_we = 1'b1;
    cfg_wdata = mk(3'd1, 1'b0, 20'h00000, 20'h00000, 20'h00001);
    req_valid = 1'b1; req_addr = 32'h0010_4000; req_special = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk("R8 old descriptor used port", 64'(rsp_port), 64'd5);
    chk("R8 old descriptor used addr", 64'(rsp_addr), 64'h0011_4000);
    mdl[0] = mk(3'd1, 1'b0, 20'h00000, 20'h00000, 20'h00001);
    send("R8 new descriptor after write", 32'h0010_4000, 1'b0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 32'h0025_0123; req_special = 1'b0;
    @(negedge clk);
    chk("R9 first result valid", 64'(rsp_valid), 64'd1);
    chk("R9 ready low when full", 64'(req_ready), 64'd0);
    req_addr = 32'h0016_0777; req_special = 1'b1;
    repeat (2) begin
      @(negedge clk);
      chk("R9 held addr", 64'(rsp_addr), 64'h0025_3123);
      chk("R9 held port", 64'(rsp_port), 64'd4);
    end
    rsp_ready = 1'b1; #1;
    chk("R9 ready follows rsp_ready", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 queued request delivered", 64'(rsp_addr), 64'h0015_F777);
    chk("R9 queued port", 64'(rsp_port), 64'd2);
    @(negedge clk);
    chk("R10 valid falls when drained", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) mdl[i] = 64'h00000000_000FFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_bounds();
    t_special();
    t_translate();
    t_priority();
    t_same_cycle();
    t_backpressure();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vectors++; miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule